// File: doc/BRIEF.md
# Memory Access Permission Checker

This block decides, one access at a time, whether a memory access may go ahead, given the translation attributes that have already been fetched for its page. A request carries the access kind (load, store or instruction fetch), the current privilege level, whether the access is of the explicitly unprivileged form, the privileged-access-never state, whether address translation is enabled, the strict alignment enable, the memory type of the page, the element size and the low address bits, and the page's permission and execute-never bits. One cycle after a request is accepted, a result appears that holds a pass flag and an encoded fault class.

Requests and results move over a valid/ready pair on each side. A request is taken on any clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the result register is empty or its current result is being taken in the same cycle, so a stalled consumer stalls the producer with no extra storage. A result that is not taken stays unchanged until `res_ready` rises. All request fields are only sampled on the accepting edge.

Top module: `mem_access_checker`

## Requirements
- R1: A request is accepted on an edge with `req_valid` and `req_ready` high; `req_ready` equals `!res_valid || res_ready`; the result is valid on the following cycle and holds its value while `res_valid` is high and `res_ready` is low. After reset `res_valid` is low.
- R2: `res_fault` encodes 00 = no fault, 01 = permission fault, 10 = alignment fault, and is never 11; `res_pass` is high exactly when `res_fault` is 00.
- R3: With `req_kind` 00 = load, 01 = store, 10 = fetch, 11 = handled as a load, and `req_ap` bit 1 = read-only and bit 0 = user accessible (00 privileged read/write, 01 read/write for all, 10 privileged read-only, 11 read-only for all): a load or store checked at user level faults when bit 0 is clear, and a store faults when bit 1 is set.
- R4: When `req_pan` is high, an ordinary load or store at the privileged level (`req_priv` = 1) to a page with `req_ap` bit 0 set raises a permission fault.
- R5: A load or store with `req_unpriv` high at the privileged level is checked with user-level permissions and is never blocked by `req_pan`; `req_unpriv` has no effect on fetches.
- R6: A fetch at user level (`req_priv` = 0) faults when `req_uxn` is set; a fetch at the privileged level faults when `req_pxn` is set.
- R7: A page writable at user level (`req_ap` = 01) faults on a privileged fetch regardless of `req_pxn`.
- R8: The element size is 2 to the power `req_size` bytes (for a pair access the size of one element); an access is aligned when the low `req_size` bits of `req_addr_lo` are zero, and when the size exceeds the low address field, when the whole field is zero.
- R9: An unaligned access to a Device page (`req_device` = 1) raises an alignment fault; an unaligned access to a Normal page raises one only when `req_align_en` is high.
- R10: With `req_mmu_on` low no permission fault is raised, loads and stores follow the Device alignment rule whatever `req_device` says, and fetches follow the Normal rule.
- R11: When an alignment fault and a permission fault both apply, the alignment fault is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 as load |
| req_priv | input | 1 | 1 = privileged level, 0 = user level |
| req_unpriv | input | 1 | Explicitly unprivileged load/store form |
| req_pan | input | 1 | Privileged-access-never state |
| req_mmu_on | input | 1 | Address translation enabled |
| req_align_en | input | 1 | Strict alignment checking for Normal pages |
| req_device | input | 1 | 1 = Device page, 0 = Normal page |
| req_size | input | SIZE_W | Log2 of element size in bytes |
| req_addr_lo | input | ADDR_LO_W | Low address bits |
| req_ap | input | 2 | Access permission field |
| req_uxn | input | 1 | User execute-never |
| req_pxn | input | 1 | Privileged execute-never |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_pass | output | 1 | Access allowed |
| res_fault | output | 2 | Fault class |

## Verification
The assertions take for granted that request fields are meaningful only on an accepting edge and that `res_ready` may drop at any time, including while a result waits; they relate what is accepted to the result one cycle later and make no claim about fields while `req_valid` is low. The stimulus drives every field at the falling clock edge, toggles `res_ready` at random to hold results for several cycles, and sweeps sizes both below and above the width of the low address field, so every alignment and permission path is reached with the handshake stalled and free-running.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'b00,
    KIND_STORE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_PERM  = 2'b01,
    FLT_ALIGN = 2'b10
  } fault_e;

  // Page attributes as seen by the permission logic
  typedef struct packed {
    logic read_only;   // permission field bit 1
    logic user_ok;     // permission field bit 0
    logic uxn;
    logic pxn;
  } page_attr_t;

endpackage

// File: rtl/mac_perm.sv
module mac_perm
  import mac_pkg::*;
(
  input  acc_kind_e  kind,
  input  logic       priv,
  input  logic       unpriv,
  input  logic       pan,
  input  page_attr_t attr,
  output logic       perm_flt
);

  logic is_fetch;
  logic is_store;
  logic user_view;
  logic deny_user;
  logic deny_ro;
  logic deny_pan;
  logic deny_fetch;
  logic user_writable;

  assign is_fetch      = (kind == KIND_FETCH);
  assign is_store      = (kind == KIND_STORE);
  // Data accesses are judged as user-level when issued at user level or
  // when the unprivileged form is used at the privileged level.
  assign user_view     = !priv || unpriv;
  assign user_writable = attr.user_ok && !attr.read_only;

  always_comb begin
    deny_user = 1'b0;
    deny_ro   = 1'b0;
    deny_pan  = 1'b0;
    if (!is_fetch) begin
      deny_user = user_view && !attr.user_ok;
      deny_ro   = is_store && attr.read_only;
      deny_pan  = priv && !unpriv && pan && attr.user_ok;
    end
  end

  always_comb begin
    deny_fetch = 1'b0;
    if (is_fetch) begin
      if (priv) begin
        deny_fetch = attr.pxn || user_writable;
      end else begin
        deny_fetch = attr.uxn;
      end
    end
  end

  assign perm_flt = deny_user || deny_ro || deny_pan || deny_fetch;

endmodule

// File: rtl/mac_align.sv
module mac_align #(
  parameter int SIZE_W    = 3,
  parameter int ADDR_LO_W = 4
) (
  input  logic [SIZE_W-1:0]    size,
  input  logic [ADDR_LO_W-1:0] addr_lo,
  input  logic                 device_eff,
  input  logic                 align_en,
  output logic                 align_flt
);

  logic [ADDR_LO_W-1:0] low_mask;
  logic                 misaligned;

  // Bit g of the address matters when the element spans more than 2**g bytes.
  for (genvar g = 0; g < ADDR_LO_W; g++) begin : g_mask
    assign low_mask[g] = (int'(size) > g);
  end

  assign misaligned = |(addr_lo & low_mask);
  assign align_flt  = misaligned && (device_eff || align_en);

endmodule

// File: rtl/mac_stage.sv
module mac_stage
  import mac_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  output logic   in_ready,
  input  fault_e in_fault,
  output logic   out_valid,
  input  logic   out_ready,
  output logic   out_pass,
  output fault_e out_fault
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= FLT_NONE;
      out_pass  <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_fault <= in_fault;
      out_pass  <= (in_fault == FLT_NONE);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/mem_access_checker.sv
module mem_access_checker
  import mac_pkg::*;
#(
  parameter int SIZE_W    = 3,
  parameter int ADDR_LO_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_kind,
  input  logic                 req_priv,
  input  logic                 req_unpriv,
  input  logic                 req_pan,
  input  logic                 req_mmu_on,
  input  logic                 req_align_en,
  input  logic                 req_device,
  input  logic [SIZE_W-1:0]    req_size,
  input  logic [ADDR_LO_W-1:0] req_addr_lo,
  input  logic [1:0]           req_ap,
  input  logic                 req_uxn,
  input  logic                 req_pxn,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic                 res_pass,
  output logic [1:0]           res_fault
);

  acc_kind_e  kind;
  page_attr_t attr;
  logic       perm_flt;
  logic       align_flt;
  logic       device_eff;
  fault_e     fault_d;
  fault_e     fault_q;

  assign kind = acc_kind_e'(req_kind);
  assign attr = '{read_only: req_ap[1], user_ok: req_ap[0],
                  uxn: req_uxn, pxn: req_pxn};

  // Without translation, data goes to strongly ordered device space and
  // fetches behave as Normal.
  assign device_eff = req_mmu_on ? req_device : (kind != KIND_FETCH);

  mac_perm u_perm (
    .kind     (kind),
    .priv     (req_priv),
    .unpriv   (req_unpriv),
    .pan      (req_pan),
    .attr     (attr),
    .perm_flt (perm_flt)
  );

  mac_align #(
    .SIZE_W    (SIZE_W),
    .ADDR_LO_W (ADDR_LO_W)
  ) u_align (
    .size       (req_size),
    .addr_lo    (req_addr_lo),
    .device_eff (device_eff),
    .align_en   (req_align_en),
    .align_flt  (align_flt)
  );

  always_comb begin
    if (align_flt)                   fault_d = FLT_ALIGN;
    else if (req_mmu_on && perm_flt) fault_d = FLT_PERM;
    else                             fault_d = FLT_NONE;
  end

  mac_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_fault  (fault_d),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_pass  (res_pass),
    .out_fault (fault_q)
  );

  assign res_fault = fault_q;

endmodule

// File: rtl/mac_checker.sv
module mac_checker #(
  parameter int SIZE_W    = 3,
  parameter int ADDR_LO_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [1:0]           req_kind,
  input logic                 req_priv,
  input logic                 req_unpriv,
  input logic                 req_pan,
  input logic                 req_mmu_on,
  input logic                 req_align_en,
  input logic                 req_device,
  input logic [SIZE_W-1:0]    req_size,
  input logic [ADDR_LO_W-1:0] req_addr_lo,
  input logic [1:0]           req_ap,
  input logic                 req_uxn,
  input logic                 req_pxn,
  input logic                 res_valid,
  input logic                 res_ready,
  input logic                 res_pass,
  input logic [1:0]           res_fault
);

  logic fire;
  assign fire = req_valid && req_ready;

  // R1
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_fault) && $stable(res_pass));

  // R1
  result_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> res_valid);

  // R2
  fault_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_fault != 2'b11);

  // R2
  pass_matches_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_pass == (res_fault == 2'b00)));

  // R3
  store_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && req_kind == 2'b01 && req_mmu_on && req_ap[1] && req_addr_lo == '0
    |=> res_fault == 2'b01);

  // R6
  user_fetch_xn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && req_kind == 2'b10 && !req_priv && req_uxn && req_mmu_on && req_addr_lo == '0
    |=> res_fault == 2'b01);

  // R9 R11
  device_odd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && req_mmu_on && req_device && req_size != '0 && req_addr_lo[0]
    |=> res_fault == 2'b10);

  // R10
  no_mmu_aligned_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !req_mmu_on && req_addr_lo == '0 |=> res_pass);

endmodule

bind mem_access_checker mac_checker #(
  .SIZE_W    (SIZE_W),
  .ADDR_LO_W (ADDR_LO_W)
) u_chk (.*);

// File: tb/mem_access_checker_tb.sv
module mem_access_checker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 3;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = '0;
  logic          req_priv = 1'b0;
  logic          req_unpriv = 1'b0;
  logic          req_pan = 1'b0;
  logic          req_mmu_on = 1'b1;
  logic          req_align_en = 1'b0;
  logic          req_device = 1'b0;
  logic [SW-1:0] req_size = '0;
  logic [AW-1:0] req_addr_lo = '0;
  logic [1:0]    req_ap = '0;
  logic          req_uxn = 1'b0;
  logic          req_pxn = 1'b0;
  logic          res_valid;
  logic          res_ready = 1'b1;
  logic          res_pass;
  logic [1:0]    res_fault;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state: queue holding at most one expected result
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_access_checker #(.SIZE_W(SW), .ADDR_LO_W(AW)) u_dut (.*);

  function automatic logic [1:0] ref_fault(
    input logic [1:0] k, input bit pv, input bit up, input bit pn, input bit mmu,
    input bit aen, input bit dev, input int sz, input int addr, input logic [1:0] ap,
    input bit ux, input bit px);
    int  esz;
    bit  unal, devlike, usr;
    esz = 1 << sz;
    unal = (addr % esz) != 0;
    if (mmu) devlike = dev;
    else     devlike = (k != 2'b10);
    if (unal && (devlike || aen)) return 2'b10;
    if (!mmu) return 2'b00;
    if (k == 2'b10) begin
      if (!pv) return ux ? 2'b01 : 2'b00;
      if (px || ap == 2'b01) return 2'b01;
      return 2'b00;
    end
    usr = !pv || up;
    if (usr && !ap[0]) return 2'b01;
    if (k == 2'b01 && ap[1]) return 2'b01;
    if (pv && !up && pn && ap[0]) return 2'b01;
    return 2'b00;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge with request fields already driven.
  task automatic step(input bit v, input bit rr, input string tag);
    bit exp_rdy;
    req_valid = v;
    res_ready = rr;
    #1;
    exp_rdy = (exp_q.size() == 0) || rr;
    check(req_ready == exp_rdy, "R1", "req_ready", req_ready, exp_rdy);
    if (exp_q.size() != 0 && rr) begin
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    if (v && exp_rdy) begin
      exp_q.push_back(ref_fault(req_kind, req_priv, req_unpriv, req_pan, req_mmu_on,
                                req_align_en, req_device, int'(req_size),
                                int'(req_addr_lo), req_ap, req_uxn, req_pxn));
      tag_q.push_back(tag);
    end
    @(posedge clk);
    @(negedge clk);
    check(res_valid == (exp_q.size() != 0), "R1", "res_valid", res_valid, exp_q.size());
    if (exp_q.size() != 0) begin
      check(res_fault == exp_q[0], tag_q[0], "res_fault", res_fault, exp_q[0]);
      check(res_pass == (exp_q[0] == 2'b00), "R2", "res_pass", res_pass,
            int'(exp_q[0] == 2'b00));
    end
  endtask

  task automatic req(input string tag, input logic [1:0] k, input bit pv, input bit up,
                     input bit pn, input bit mmu, input bit aen, input bit dev,
                     input int sz, input int addr, input logic [1:0] ap,
                     input bit ux, input bit px);
    req_kind = k; req_priv = pv; req_unpriv = up; req_pan = pn; req_mmu_on = mmu;
    req_align_en = aen; req_device = dev; req_size = SW'(sz); req_addr_lo = AW'(addr);
    req_ap = ap; req_uxn = ux; req_pxn = px;
    step(1'b1, 1'b1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL R1 watchdog: actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R1)
    check(res_valid == 1'b0, "R1", "reset res_valid", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "idle req_ready", req_ready, 1);

    //        tag   kind  pv up pn mmu aen dev sz addr ap    ux px
    // R3 basic permission field
    req("R3", 2'b00, 0, 0, 0, 1, 0, 0, 0, 0, 2'b00, 0, 0);
    req("R3", 2'b00, 0, 0, 0, 1, 0, 0, 0, 0, 2'b01, 0, 0);
    req("R3", 2'b01, 1, 0, 0, 1, 0, 0, 0, 0, 2'b10, 0, 0);
    req("R3", 2'b01, 0, 0, 0, 1, 0, 0, 0, 0, 2'b11, 0, 0);
    req("R3", 2'b11, 0, 0, 0, 1, 0, 0, 0, 0, 2'b00, 0, 0);
    req("R3", 2'b01, 1, 0, 0, 1, 0, 0, 2, 8, 2'b00, 0, 0);
    // R4 privileged-access-never
    req("R4", 2'b00, 1, 0, 1, 1, 0, 0, 0, 0, 2'b01, 0, 0);
    req("R4", 2'b00, 1, 0, 0, 1, 0, 0, 0, 0, 2'b01, 0, 0);
    req("R4", 2'b01, 1, 0, 1, 1, 0, 0, 0, 0, 2'b00, 0, 0);
    req("R4", 2'b01, 1, 0, 1, 1, 0, 0, 0, 0, 2'b11, 0, 0);
    // R5 unprivileged form
    req("R5", 2'b00, 1, 1, 1, 1, 0, 0, 0, 0, 2'b01, 0, 0);
    req("R5", 2'b00, 1, 1, 0, 1, 0, 0, 0, 0, 2'b00, 0, 0);
    req("R5", 2'b10, 1, 1, 1, 1, 0, 0, 0, 0, 2'b00, 0, 0);
    // R6 execute-never
    req("R6", 2'b10, 0, 0, 0, 1, 0, 0, 0, 0, 2'b11, 1, 0);
    req("R6", 2'b10, 0, 0, 0, 1, 0, 0, 0, 0, 2'b11, 0, 1);
    req("R6", 2'b10, 1, 0, 0, 1, 0, 0, 0, 0, 2'b00, 0, 1);
    req("R6", 2'b10, 1, 0, 0, 1, 0, 0, 0, 0, 2'b00, 1, 0);
    // R7 user-writable page not executable when privileged
    req("R7", 2'b10, 1, 0, 0, 1, 0, 0, 0, 0, 2'b01, 0, 0);
    req("R7", 2'b10, 1, 0, 0, 1, 0, 0, 0, 0, 2'b11, 0, 0);
    req("R7", 2'b10, 0, 0, 0, 1, 0, 0, 0, 0, 2'b01, 0, 0);
    // R8 element-size alignment
    req("R8", 2'b00, 1, 0, 0, 1, 0, 1, 2, 4, 2'b00, 0, 0);
    req("R8", 2'b00, 1, 0, 0, 1, 0, 1, 2, 2, 2'b00, 0, 0);
    req("R8", 2'b00, 1, 0, 0, 1, 0, 1, 7, 0, 2'b00, 0, 0);
    req("R8", 2'b00, 1, 0, 0, 1, 0, 1, 5, 8, 2'b00, 0, 0);
    req("R8", 2'b00, 1, 0, 0, 1, 0, 1, 0, 15, 2'b00, 0, 0);
    req("R8", 2'b00, 1, 0, 0, 1, 0, 1, 3, 8, 2'b00, 0, 0);
    // R9 Device versus Normal
    req("R9", 2'b00, 1, 0, 0, 1, 0, 0, 1, 1, 2'b00, 0, 0);
    req("R9", 2'b00, 1, 0, 0, 1, 1, 0, 1, 1, 2'b00, 0, 0);
    req("R9", 2'b01, 1, 0, 0, 1, 0, 1, 3, 4, 2'b00, 0, 0);
    req("R9", 2'b10, 1, 0, 0, 1, 0, 1, 2, 2, 2'b00, 0, 0);
    // R10 translation disabled
    req("R10", 2'b01, 0, 0, 1, 0, 0, 0, 0, 0, 2'b11, 1, 1);
    req("R10", 2'b10, 1, 0, 0, 0, 0, 0, 0, 0, 2'b01, 1, 1);
    req("R10", 2'b00, 0, 0, 0, 0, 0, 0, 1, 1, 2'b01, 0, 0);
    req("R10", 2'b10, 0, 0, 0, 0, 0, 1, 1, 1, 2'b01, 1, 0);
    req("R10", 2'b10, 0, 0, 0, 0, 1, 1, 1, 1, 2'b01, 0, 0);
    // R11 alignment wins over permission
    req("R11", 2'b01, 0, 0, 0, 1, 0, 1, 1, 1, 2'b11, 0, 0);
    req("R11", 2'b10, 1, 0, 0, 1, 1, 0, 2, 1, 2'b01, 0, 1);

    // R1 back-pressure: result held, producer stalled
    req_kind = 2'b01; req_priv = 0; req_ap = 2'b11; req_addr_lo = '0; req_size = '0;
    req_mmu_on = 1; req_device = 0; req_align_en = 0;
    step(1'b1, 1'b1, "R1");
    req_ap = 2'b01;
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b1, "R1");
    step(1'b0, 1'b1, "R1");
    step(1'b0, 1'b1, "R1");

    // random traffic with random back-pressure
    for (int i = 0; i < 4000; i++) begin
      req_kind     = 2'($urandom);
      req_priv     = 1'($urandom);
      req_unpriv   = 1'($urandom);
      req_pan      = 1'($urandom);
      req_mmu_on   = ($urandom % 5) != 0;
      req_align_en = 1'($urandom);
      req_device   = 1'($urandom);
      req_size     = SW'($urandom);
      req_addr_lo  = (($urandom % 3) == 0) ? AW'($urandom) : '0;
      req_ap       = 2'($urandom);
      req_uxn      = 1'($urandom);
      req_pxn      = 1'($urandom);
      step(1'($urandom), ($urandom % 4) != 0, "R2");
    end
    step(1'b0, 1'b1, "R2");
    step(1'b0, 1'b1, "R2");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule